// File: doc/BRIEF.md
# Manchester Line Encoder with Pre-emphasis Taps

The block turns a serial NRZ transmit stream from a media access controller into a 10 Mb/s Manchester line signal. It runs from a 20 MHz reference clock, so one reference cycle is one half-bit. It divides that reference by two and returns the result to the controller as the transmit clock. The controller presents each bit and a transmit enable against that clock.

Four digital outputs leave the block. The first two are a true and complement Manchester pair. The other two are the same pair delayed by one half-bit. An external resistor network joins each direct output with the delayed output of opposite polarity. The 100 ns pulses are then weakened relative to the 50 ns pulses, which compensates for the low-pass loss of twisted-pair cable.

A select input picks the idle line convention. In the first convention the idle line holds a non-zero differential. In the second, both outputs rest at the same level, so a transformer-coupled load sees zero differential.

Top module: `manchester_tx`

## Requirements
- R1: `txClk` is low during reset and toggles on every rising edge of `clk` after reset, giving half the reference frequency.
- R2: `txEn` and `txData` are sampled only at rising edges of `clk` at which `txClk` is high (bit boundaries). When `txEn` is high there, that bit is driven during the next two `clk` cycles: first half, then second half.
- R3: Bit coding: for a one, `outP` is low in the first half and high in the second half. For a zero, `outP` is high and then low. While a bit is driven, `outN` is the complement of `outP`, so every bit has a transition at mid-bit.
- R4: When `idleSel` is 0 and no bit is being driven, `outP` is 1 and `outN` is 0.
- R5: When `idleSel` is 1 and no bit is being driven, `outP` and `outN` are both 0.
- R6: While a bit is driven, `outPDly` and `outNDly` equal `outP` and `outN` of the previous `clk` cycle. This holds for the first half of a burst too, where the delayed pair carries the idle levels.
- R7: While no bit is driven, `outPDly` equals `outP` and `outNDly` equals `outN`.
- R8: A bit that has started always completes both halves. A drop or change of `txEn` or `txData` between bit boundaries has no effect on the line.
- R9: `idleSel` has no effect on any output while a bit is being driven.
- R10: Right after reset the line is idle: the outputs follow R4 or R5, and the delayed pair matches the direct pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz reference clock, one half-bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Transmit enable from the controller, sampled at bit boundaries |
| txData | input | 1 | NRZ transmit bit, sampled together with `txEn` |
| idleSel | input | 1 | Idle convention: 0 = non-zero differential, 1 = zero differential |
| txClk | output | 1 | Reference divided by two, returned to the controller |
| outP | output | 1 | Direct Manchester output, true polarity |
| outN | output | 1 | Direct Manchester output, complement polarity |
| outPDly | output | 1 | `outP` delayed by one half-bit |
| outNDly | output | 1 | `outN` delayed by one half-bit |

## Verification
Two kinds of event can land on the same cycle. The first is a bit boundary at which the enable falls while the previous bit's second half is still on the line. The second is a change of the idle select in the middle of a driven bit, which must not reach the line until the bit ends. The bench sweeps every four-bit pattern under both idle conventions. In one pass it also inverts enable and data and flips the idle select during each first half, then restores them before the next boundary. Each sampled cycle is compared against a line model in the bench. That model derives the direct pair from the bit value and half, and the delayed pair from the previously expected sample.

// File: rtl/manchester_tx_pkg.sv
package manchester_tx_pkg;

  // Strobes from the half-bit sequencer to the line datapath.
  typedef struct packed {
    logic load;    // bit boundary with enable: capture a new bit, drive its first half
    logic second;  // drive the second half of the bit in flight
    logic lineOn;  // a bit is on the line in the current cycle
  } mtxStrobe_t;

endpackage

// File: rtl/manchester_tx_ctrl.sv
module manchester_tx_ctrl
  import manchester_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  output logic       txClk,
  output mtxStrobe_t strobes
);

  logic phaseQ;   // 1 in the cycle that ends at a bit boundary
  logic activeQ;  // a bit half is on the line
  logic loadW;
  logic secondW;

  assign loadW   = phaseQ & txEn;
  assign secondW = ~phaseQ & activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      phaseQ  <= ~phaseQ;
      activeQ <= loadW | secondW;
    end
  end

  assign txClk          = phaseQ;
  assign strobes.load   = loadW;
  assign strobes.second = secondW;
  assign strobes.lineOn = activeQ;

endmodule

// File: rtl/manchester_tx_dp.sv
module manchester_tx_dp
  import manchester_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txData,
  input  logic       idleSel,
  input  mtxStrobe_t strobes,
  output logic       outP,
  output logic       outN,
  output logic       outPDly,
  output logic       outNDly
);

  logic bitQ;    // bit in flight
  logic lineQ;   // true-polarity level while a bit is on the line
  logic prevPQ;  // direct pair one half-bit ago
  logic prevNQ;
  logic idleP;

  // Idle level: non-zero differential (P high) or both outputs low.
  assign idleP = ~idleSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitQ   <= 1'b0;
      lineQ  <= 1'b0;
      prevPQ <= 1'b1;
      prevNQ <= 1'b0;
    end else begin
      if (strobes.load) bitQ <= txData;
      // First half carries the inverted bit, second half the bit itself.
      lineQ  <= strobes.load ? ~txData : bitQ;
      prevPQ <= outP;
      prevNQ <= outN;
    end
  end

  always_comb begin
    if (strobes.lineOn) begin
      outP    = lineQ;
      outN    = ~lineQ;
      outPDly = prevPQ;
      outNDly = prevNQ;
    end else begin
      outP    = idleP;
      outN    = 1'b0;
      outPDly = idleP;
      outNDly = 1'b0;
    end
  end

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import manchester_tx_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic txEn,
  input  logic txData,
  input  logic idleSel,
  output logic txClk,
  output logic outP,
  output logic outN,
  output logic outPDly,
  output logic outNDly
);

  mtxStrobe_t strobes;
  logic       lineOn;

  assign lineOn = strobes.lineOn;

  manchester_tx_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txEn    (txEn),
    .txClk   (txClk),
    .strobes (strobes)
  );

  manchester_tx_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .txData  (txData),
    .idleSel (idleSel),
    .strobes (strobes),
    .outP    (outP),
    .outN    (outN),
    .outPDly (outPDly),
    .outNDly (outNDly)
  );

endmodule

module manchester_tx_chk (
  input logic clk,
  input logic rstN,
  input logic idleSel,
  input logic txClk,
  input logic outP,
  input logic outN,
  input logic outPDly,
  input logic outNDly,
  input logic lineOn
);

  // R1
  txclk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (txClk != $past(txClk)));

  // R2
  start_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOn) |-> !txClk);

  // R3
  midbit_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineOn && !txClk) |=> (lineOn && outP != $past(outP)));

  // R5
  equal_only_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outP == outN) |-> (!outP && idleSel && !lineOn));

  // R6
  dly_follows_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineOn |-> (outPDly == $past(outP) && outNDly == $past(outN)));

  // R7
  dly_idle_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineOn |-> (outPDly == outP && outNDly == outN));

endmodule

bind manchester_tx manchester_tx_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .idleSel (idleSel),
  .txClk   (txClk),
  .outP    (outP),
  .outN    (outN),
  .outPDly (outPDly),
  .outNDly (outNDly),
  .lineOn  (lineOn)
);

// File: tb/test_manchester_tx.sv
`timescale 1ns/1ps
module test_manchester_tx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b0;
  logic txData = 1'b0;
  logic idleSel = 1'b0;
  logic txClk, outP, outN, outPDly, outNDly;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // previously expected sample
  logic pvP = 1'b1, pvN = 1'b0, pvClk = 1'b0;

  always #2.5 clk = ~clk;

  manchester_tx i_manchester_tx (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txData(txData), .idleSel(idleSel),
    .txClk(txClk), .outP(outP), .outN(outN), .outPDly(outPDly), .outNDly(outNDly)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected end before 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // One sampled cycle: act = bit on line, eP/eN = expected direct pair.
  task automatic step(input logic act, input logic eP, input logic eN, input string tag);
    logic edP, edN, eClk;
    @(negedge clk);
    edP  = act ? pvP : eP;
    edN  = act ? pvN : eN;
    eClk = ~pvClk;
    checks++;
    if (outP !== eP || outN !== eN || outPDly !== edP || outNDly !== edN || txClk !== eClk) begin
      fails++;
      $display("FAIL %s (R1 R6 R7): got clk=%b P=%b N=%b Pd=%b Nd=%b expected clk=%b P=%b N=%b Pd=%b Nd=%b",
               tag, txClk, outP, outN, outPDly, outNDly, eClk, eP, eN, edP, edN);
    end
    pvP = eP; pvN = eN; pvClk = eClk;
  endtask

  task automatic stepIdle();
    step(1'b0, ~idleSel, 1'b0, idleSel ? "R5 idle" : "R4 idle");
  endtask

  // Send a 4-bit pattern MSB first; glitch disturbs inputs between boundaries.
  task automatic sendPattern(input logic [3:0] pat, input bit glitch);
    logic b;
    logic keepSel;
    while (pvClk != 1'b1) stepIdle();
    for (int i = 3; i >= 0; i--) begin
      b = pat[i];
      txEn = 1'b1;
      txData = b;
      step(1'b1, ~b, b, "R2 R3 first half");
      if (glitch) begin
        // R8 R9: disturb enable, data and idle select inside the bit
        keepSel = idleSel;
        txEn = 1'b0;
        txData = ~b;
        idleSel = ~idleSel;
        step(1'b1, b, ~b, "R8 R9 second half");
        idleSel = keepSel;
      end else begin
        step(1'b1, b, ~b, "R3 second half");
      end
    end
    txEn = 1'b0;
    for (int k = 0; k < 3; k++) stepIdle();
  endtask

  initial begin
    // R10 R1: line idle and txClk low while in reset, both conventions
    repeat (2) @(negedge clk);
    idleSel = 1'b0;
    #0.1;
    checks++;
    if (txClk !== 1'b0 || outP !== 1'b1 || outN !== 1'b0 || outPDly !== 1'b1 || outNDly !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset sel0: got clk=%b P=%b N=%b Pd=%b Nd=%b expected 0 1 0 1 0",
               txClk, outP, outN, outPDly, outNDly);
    end
    idleSel = 1'b1;
    #0.1;
    checks++;
    if (txClk !== 1'b0 || outP !== 1'b0 || outN !== 1'b0 || outPDly !== 1'b0 || outNDly !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset sel1: got clk=%b P=%b N=%b Pd=%b Nd=%b expected 0 0 0 0 0",
               txClk, outP, outN, outPDly, outNDly);
    end
    idleSel = 1'b0;
    pvClk = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    pvP = 1'b1; pvN = 1'b0;

    for (int sel = 0; sel < 2; sel++) begin
      for (int g = 0; g < 2; g++) begin
        for (int pat = 0; pat < 16; pat++) begin
          idleSel = sel[0];
          sendPattern(pat[3:0], g[0]);
        end
      end
    end

    // R8: enable raised only while txClk is low, then dropped before the boundary
    while (pvClk != 1'b0) stepIdle();
    txEn = 1'b1;
    txData = 1'b1;
    stepIdle();
    txEn = 1'b0;
    for (int k = 0; k < 4; k++) stepIdle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule